// File: doc/BRIEF.md
# Memory-Bus Event Interrupt and Wait-Input Controller

This block gathers the event sources of an external memory controller into one small interrupt controller. Two single-cycle event pulses from the controller's datapath, a FIFO-level event and a transfer terminal-count event, share an interrupt vector with the wait inputs of the memory bus. An edge detector watches each wait input. Each edge detector triggers on a rising or a falling transition, chosen per pin.

Every source has a sticky status bit and an enable bit. Status bits are cleared by writing 1 to them. The registered OR of all enabled pending bits drives one interrupt line. Because the wait pins are asynchronous, each one passes through a two-flop synchronizer. The synchronized levels feed the edge detectors and can also be read as plain general-purpose inputs.

The source numbering is fixed and software depends on it:
- bit 0 is the FIFO event;
- bit 1 is the terminal-count event;
- bit 2+i is the edge source of wait input i.

The number of wait inputs is a parameter.

Top module: `memevt_irq_ctrl`

## Requirements
- R1: While reset is asserted, and immediately after it, the status, enable and edge-select registers read 0 and `irq_o` is 0.
- R2: A one-cycle pulse on `fifo_evt_i` sets status bit 0, and a pulse on `tc_evt_i` sets status bit 1. Both bits are set on the next clock edge. A set bit stays set until software clears it.
- R3: Status bit 2+i is set by an edge on wait input i. The edge-select bit i decides which edge counts: 1 selects rising and 0 selects falling. A transition in the other direction leaves the bit unchanged.
- R4: Each wait input passes through two synchronizer flops. A change on pin i appears in bit i of the readback register (address 0xC) two clock edges after the change. The matching status bit is set on the third edge.
- R5: Writing address 0x0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R6: If a source's event arrives in the same cycle as a clear of its status bit, the bit ends up set.
- R7: `irq_o` is the OR over all sources of (status AND enable). It is registered, so it follows a change of status or enable one clock edge later.
- R8: The register map is as follows:
  - 0x4 holds the enables in bits NUM_WAIT+1..0.
  - 0x8 holds the edge selects in bits NUM_WAIT-1..0.
  - 0x0 reads the status.
  - 0xC reads the synchronized wait levels and ignores writes.
  - Bits above each field read 0.
- R9: Any other address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_evt_i | input | 1 | FIFO event pulse (source 0) |
| tc_evt_i | input | 1 | Terminal-count event pulse (source 1) |
| wait_i | input | NUM_WAIT | Asynchronous wait inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is an edge on one particular wait pin that must be judged against its own edge-select bit. Any earlier transition on that pin leaves a stale status bit behind, and the three-edge synchronizer delay hides exactly when the new bit appears.

The stimulus handles this in three steps:
1. It parks the pin at the level opposite the tested direction, lets the synchronizer settle, and clears status.
2. It makes exactly one transition.
3. It samples the readback after one edge and after two edges, and samples status after the third edge.

It repeats this for every pin, select value and direction. A second hard case is an event arriving in the same cycle as its write-1 clear. The bench reaches it by raising the FIFO pulse at the same falling edge as the register write.

// File: rtl/memevt_pkg.sv
package memevt_pkg;
  localparam int REG_ADDR_W = 4;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 4'h0;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 4'h4;
  localparam logic [REG_ADDR_W-1:0] ADDR_EDGESEL = 4'h8;
  localparam logic [REG_ADDR_W-1:0] ADDR_PINS = 4'hC;
  localparam int FIXED_SRC = 2;
  localparam int SRC_FIFO = 0;
  localparam int SRC_TC = 1;
endpackage

// File: rtl/memevt_rst_sync.sv
module memevt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/memevt_wait_sync.sv
module memevt_wait_sync #(
  parameter int NUM_WAIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAIT-1:0] pin_i,
  output logic [NUM_WAIT-1:0] level_o,
  output logic [NUM_WAIT-1:0] rise_o,
  output logic [NUM_WAIT-1:0] fall_o
);
  for (genvar g = 0; g < NUM_WAIT; g++) begin : g_pin
    logic meta_q, lvl_q, prev_q;
    logic meta_d, lvl_d, prev_d;

    always_comb begin
      meta_d = pin_i[g];
      lvl_d  = meta_q;
      prev_d = lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        lvl_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        lvl_q  <= lvl_d;
        prev_q <= prev_d;
      end
    end

    assign level_o[g] = lvl_q;
    assign rise_o[g]  = lvl_q & ~prev_q;
    assign fall_o[g]  = ~lvl_q & prev_q;
  end
endmodule

// File: rtl/memevt_regs.sv
module memevt_regs
  import memevt_pkg::*;
#(
  parameter int NUM_WAIT = 2,
  localparam int NUM_SRC = NUM_WAIT + FIXED_SRC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0]    wdata_i,
  input  logic [NUM_SRC-1:0]    evt_i,
  output logic [NUM_SRC-1:0]    status_o,
  output logic [NUM_SRC-1:0]    enable_o,
  output logic [NUM_WAIT-1:0]   edgesel_o
);
  logic [NUM_SRC-1:0]  status_q, status_d, clr_mask;
  logic [NUM_SRC-1:0]  enable_q, enable_d;
  logic [NUM_WAIT-1:0] edgesel_q, edgesel_d;
  logic                enable_ld, edgesel_ld;

  always_comb begin
    clr_mask   = (we_i && addr_i == ADDR_STATUS) ? wdata_i : '0;
    enable_ld  = we_i && (addr_i == ADDR_ENABLE);
    edgesel_ld = we_i && (addr_i == ADDR_EDGESEL);
    // a fresh event overrides a clear of the same bit
    status_d   = (status_q & ~clr_mask) | evt_i;
    enable_d   = enable_ld ? wdata_i : enable_q;
    edgesel_d  = edgesel_ld ? wdata_i[NUM_WAIT-1:0] : edgesel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      enable_q  <= '0;
      edgesel_q <= '0;
    end else begin
      status_q <= status_d;
      if (enable_ld)  enable_q  <= enable_d;
      if (edgesel_ld) edgesel_q <= edgesel_d;
    end
  end

  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign edgesel_o = edgesel_q;
endmodule

// File: rtl/memevt_irq_ctrl.sv
module memevt_irq_ctrl
  import memevt_pkg::*;
#(
  parameter int NUM_WAIT = 2,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_evt_i,
  input  logic                  tc_evt_i,
  input  logic [NUM_WAIT-1:0]   wait_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  localparam int NUM_SRC = NUM_WAIT + FIXED_SRC;

  logic                rst_sync_n;
  logic [NUM_WAIT-1:0] wait_lvl, wait_rise, wait_fall, wait_trig, edgesel_q;
  logic [NUM_SRC-1:0]  evt_vec, status_q, enable_q;
  logic                irq_q, irq_d;

  memevt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  memevt_wait_sync #(.NUM_WAIT(NUM_WAIT)) u_wsync (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(wait_i),
    .level_o(wait_lvl), .rise_o(wait_rise), .fall_o(wait_fall)
  );

  for (genvar g = 0; g < NUM_WAIT; g++) begin : g_trig
    assign wait_trig[g] = edgesel_q[g] ? wait_rise[g] : wait_fall[g];
  end

  always_comb begin
    evt_vec = '0;
    evt_vec[SRC_FIFO] = fifo_evt_i;
    evt_vec[SRC_TC]   = tc_evt_i;
    evt_vec[NUM_SRC-1:FIXED_SRC] = wait_trig;
  end

  memevt_regs #(.NUM_WAIT(NUM_WAIT)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[NUM_SRC-1:0]), .evt_i(evt_vec),
    .status_o(status_q), .enable_o(enable_q), .edgesel_o(edgesel_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_STATUS:  reg_rdata_o[NUM_SRC-1:0]  = status_q;
      ADDR_ENABLE:  reg_rdata_o[NUM_SRC-1:0]  = enable_q;
      ADDR_EDGESEL: reg_rdata_o[NUM_WAIT-1:0] = edgesel_q;
      ADDR_PINS:    reg_rdata_o[NUM_WAIT-1:0] = wait_lvl;
      default:      reg_rdata_o = '0;
    endcase
  end

  always_comb irq_d = |(status_q & enable_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/memevt_irq_ctrl_chk.sv
module memevt_irq_ctrl_chk
  import memevt_pkg::*;
#(
  parameter int NUM_WAIT = 2,
  localparam int NUM_SRC = NUM_WAIT + FIXED_SRC
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  fifo_evt_i,
  input logic                  tc_evt_i,
  input logic [NUM_WAIT-1:0]   wait_i,
  input logic                  reg_we_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic [NUM_SRC-1:0]    wdata_lo,
  input logic [NUM_SRC-1:0]    status_q,
  input logic [NUM_SRC-1:0]    enable_q,
  input logic [NUM_WAIT-1:0]   wait_lvl,
  input logic                  irq_o
);
  logic [1:0]         up_cnt;
  logic [NUM_SRC-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  assign clr_mask = (reg_we_i && reg_addr_i == ADDR_STATUS) ? wdata_lo : '0;

  // R1
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (status_q == '0 && enable_q == '0 && irq_o == 1'b0));

  assert_fifo_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (up_cnt != 2'd0 && fifo_evt_i) |=> status_q[SRC_FIFO]);

  assert_tc_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (up_cnt != 2'd0 && tc_evt_i) |=> status_q[SRC_TC]);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (up_cnt != 2'd0) |-> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

  assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    up_cnt[1] |-> (wait_lvl == $past(wait_i, 2)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (up_cnt != 2'd0 && clr_mask[SRC_TC] && !tc_evt_i) |=> !status_q[SRC_TC]);

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (up_cnt != 2'd0) |-> (irq_o == |($past(status_q) & $past(enable_q))));
endmodule

bind memevt_irq_ctrl memevt_irq_ctrl_chk #(.NUM_WAIT(NUM_WAIT)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .fifo_evt_i(fifo_evt_i),
  .tc_evt_i(tc_evt_i), .wait_i(wait_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .wdata_lo(reg_wdata_i[NUM_SRC-1:0]),
  .status_q(status_q), .enable_q(enable_q), .wait_lvl(wait_lvl), .irq_o(irq_o)
);

// File: tb/memevt_irq_ctrl_test.sv
module memevt_irq_ctrl_test;
  localparam int NW = 2;
  localparam int NS = NW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fifo_evt, tc_evt;
  logic [NW-1:0] wait_pins;
  logic          we;
  logic [3:0]    addr;
  logic [31:0]   wdata, rdata;
  logic          irq;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  memevt_irq_ctrl #(.NUM_WAIT(NW), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_evt_i(fifo_evt), .tc_evt_i(tc_evt),
    .wait_i(wait_pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; addr = 4'hE; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 4'hE;
  endtask

  // drive every status bit to 1
  task automatic set_all();
    logic [31:0] v;
    wr(4'h8, (wait_pins == '0) ? 32'h3 : 32'h0);
    fifo_evt = 1'b1; tc_evt = 1'b1; wait_pins = ~wait_pins;
    tick();
    fifo_evt = 1'b0; tc_evt = 1'b0;
    tick(); tick();
    rd(4'h0, v);
    check("R2/R3 all sources set", v, 32'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        prev_irq;
    rst_n = 1'b0; fifo_evt = 1'b0; tc_evt = 1'b0; wait_pins = '0;
    we = 1'b0; addr = 4'hE; wdata = '0;
    repeat (3) tick();
    check("R1 irq in reset", {31'd0, irq}, 0);
    rd(4'h0, v); check("R1 status in reset", v, 0);
    rd(4'h4, v); check("R1 enable in reset", v, 0);
    rd(4'h8, v); check("R1 edgesel in reset", v, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    rd(4'h0, v); check("R1 status after reset", v, 0);
    check("R1 irq after reset", {31'd0, irq}, 0);

    // R2: single pulses, sticky
    fifo_evt = 1'b1; tick(); fifo_evt = 1'b0;
    rd(4'h0, v); check("R2 fifo sets bit0", v, 32'h1);
    repeat (3) tick();
    rd(4'h0, v); check("R2 fifo bit sticky", v, 32'h1);
    tc_evt = 1'b1; tick(); tc_evt = 1'b0;
    rd(4'h0, v); check("R2 tc sets bit1", v, 32'h3);
    wr(4'h0, 32'h2);
    rd(4'h0, v); check("R5 clear only bit1", v, 32'h1);
    wr(4'h0, 32'h1);
    rd(4'h0, v); check("R5 clear bit0", v, 32'h0);

    // R3/R4: every pin, select and direction
    for (int i = 0; i < NW; i++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int dir = 0; dir < 2; dir++) begin
          wr(4'h8, 32'(sel) << i);
          wait_pins[i] = !dir[0];
          repeat (4) tick();
          wr(4'h0, 32'hF);
          rd(4'h0, v); check("R5 cleared before edge", v, 0);
          wait_pins[i] = dir[0];
          tick();
          rd(4'hC, v); check("R4 readback after one edge", v[i], 32'(!dir[0]));
          tick();
          rd(4'hC, v); check("R4 readback after two edges", v[i], 32'(dir));
          rd(4'h0, v); check("R4 status not yet set", v, 0);
          tick();
          rd(4'h0, v);
          check("R3 edge status", v, (sel == dir) ? (32'h1 << (2 + i)) : 32'h0);
          wait_pins[i] = 1'b0;
          repeat (4) tick();
          wr(4'h0, 32'hF);
        end
      end
    end

    // R5: write-one-to-clear over every mask
    for (int m = 0; m < 16; m++) begin
      set_all();
      wr(4'h0, 32'(m));
      rd(4'h0, v); check("R5 w1c mask", v, 32'(~m & 4'hF));
      wr(4'h0, 32'hF);
      rd(4'h0, v); check("R5 clear all", v, 0);
    end

    // R6: set beats clear in the same cycle
    fifo_evt = 1'b1;
    wr(4'h0, 32'h1);
    fifo_evt = 1'b0;
    rd(4'h0, v); check("R6 event wins over clear", v, 32'h1);
    wr(4'h0, 32'h1);

    // R7: enable sweep with status 0101
    set_all();
    wr(4'h0, 32'hA);
    prev_irq = 1'b0;
    for (int en = 0; en < 16; en++) begin
      wr(4'h4, 32'(en));
      check("R7 irq one cycle late", {31'd0, irq}, {31'd0, prev_irq});
      tick();
      prev_irq = |(en[3:0] & 4'h5);
      check("R7 irq value", {31'd0, irq}, {31'd0, prev_irq});
      rd(4'h4, v); check("R8 enable readback", v, 32'(en));
    end
    wr(4'h0, 32'hF);
    tick(); tick();
    check("R7 irq drops after clear", {31'd0, irq}, 0);

    // R8: field widths and read-only pins
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R8 enable width", v, 32'hF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); check("R8 edgesel width", v, 32'h3);
    wait_pins = 2'b10;
    repeat (3) tick();
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); check("R8 pins read-only", v, 32'h2);
    wait_pins = 2'b00;
    repeat (4) tick();
    wr(4'h0, 32'hF);

    // R9: unlisted addresses
    wr(4'h4, 32'h5);
    wr(4'h8, 32'h1);
    for (int a = 0; a < 16; a++) begin
      if (a % 4 != 0) begin
        wr(4'(a), 32'hFFFF_FFFF);
        rd(4'(a), v); check("R9 unmapped reads zero", v, 0);
      end
    end
    rd(4'h4, v); check("R9 enable untouched", v, 32'h5);
    rd(4'h8, v); check("R9 edgesel untouched", v, 32'h1);
    rd(4'h0, v); check("R9 status untouched", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule